// File: doc/BRIEF.md
# Relocatable Configuration Register Window

This block is a bank of memory-mapped configuration registers reached by the host through a 64-byte window. A main mode register picks one of four window bases. The same register can hide the window so that the host reaches the memory underneath. The block holds a 23-bit flash address, a flash data access port, a 64 KB block select, 24 bank configuration bytes, an expanded-slot byte, a flash configuration byte, a volume byte and a bit-level port for a serial EEPROM. It also returns three read-only firmware version bytes.

The block select and the bank configuration bytes can be updated in a deferred way. With deferral on, host writes land only in a pending copy, and the mapper keeps seeing the active copy. The whole pending copy moves into the active copy in one clock edge, when one of these events happens: an opcode fetch from address 0000h, or a read from address 4000h, depending on the mode. The deferral flag clears at the same edge. The flash protocol and the mapper datapath sit outside this block. It supplies their register values and access strobes only.

Top module: `cfg_window_regs`

## Requirements
- R1: After reset the mode byte is 20h, the volume byte 1Bh, the flash configuration byte 02h, the expanded-slot byte 00h and the block select 00h. Each bank group of six bytes resets to F8h, 50h, 00h, mult, 03h, 40h, where mult is 85h for the first group and 00h for the others.
- R2: The window covers base to base+3Fh. The base is {mode[6:5], 14'h0F80}, which gives 0F80h, 4F80h, 8F80h or CF80h. `win_sel` is high for a read or write inside the window, and the byte offset is address bits 5:0.
- R3: While mode bit 7 is 1, `win_sel` stays low, writes in the range change nothing, and reads in the range do not update `bus_rdata`.
- R4: A write to offset 00h or to offset 1Fh loads the mode byte.
- R5: With mode bit 3 = 0, a write to offset 05h (block select) or to offsets 06h–1Dh (bank byte k = offset-06h, shown on `bank_cfg_o[8k+7:8k]`) reaches the output at the clock edge of the write.
- R6: With mode bit 3 = 1, writes to offsets 05h–1Dh change only the pending copy, and the outputs keep their values.
- R7: With mode bits 3:2 = 10, a read at 0000h with `bus_fetch` = 1 moves every pending byte to the outputs and clears mode bit 3 at one edge. A read at 0000h with `bus_fetch` = 0, or any read at 4000h, does neither.
- R8: With mode bits 3:2 = 11, any read at 4000h commits and clears bit 3. A fetch at 0000h does not.
- R9: A mode write that clears bit 3 while bit 3 is set commits the pending copy at that same edge.
- R10: Offsets 01h, 02h and 03h load flash address bits 7:0, 15:8 and 22:16, in that order (bit 7 of the write to 03h is dropped). A write to 04h gives a one-cycle `flash_wr_o` pulse, with the data on `flash_wdata_o`, in the cycle after the edge. A read of 04h raises `flash_rd_o` combinationally and returns `flash_rdata` on `bus_rdata` after the edge.
- R11: At offset 23h, write bits 3, 2 and 1 drive `ee_cs_o`, `ee_clk_o` and `ee_di_o`. A read returns {4'b0000, cs, clk, di, `ee_do_i`}.
- R12: Offsets 20h, 22h and 1Eh load the flash configuration, volume and expanded-slot bytes. Reads of 2Ch, 2Dh and 2Eh return version bytes 23:16, 15:8 and 7:0. A read of any other offset returns FFh. Read data appears one edge after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| bus_addr | input | 16 | host address |
| bus_rd | input | 1 | host read (never together with bus_wr) |
| bus_wr | input | 1 | host write |
| bus_fetch | input | 1 | the read is an opcode fetch |
| bus_wdata | input | 8 | host write data |
| win_sel | output | 1 | access falls in the visible window |
| bus_rdata | output | 8 | registered read data |
| mode_o | output | 8 | mode byte |
| slot_cfg_o | output | 8 | expanded-slot byte |
| flash_cfg_o | output | 8 | flash configuration byte |
| volume_o | output | 8 | volume byte |
| blk_sel_o | output | 8 | active 64 KB block select |
| bank_cfg_o | output | 192 | active bank configuration bytes |
| flash_addr_o | output | 23 | flash access address |
| flash_wdata_o | output | 8 | flash write data |
| flash_wr_o | output | 1 | flash write pulse |
| flash_rd_o | output | 1 | flash read strobe |
| flash_rdata | input | 8 | flash read data |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_clk_o | output | 1 | EEPROM clock |
| ee_di_o | output | 1 | data to EEPROM |
| ee_do_i | input | 1 | data from EEPROM |

## Verification
A commit and a mode-register write can land on the same edge. This happens when the host writes a mode byte with bit 3 cleared while deferral is active: the pending copy must move across at that edge, and the written byte must win over the automatic clear of bit 3. The random sequence mixes deferred writes, relocating mode writes that turn deferral on and off, and reads at 0000h and 4000h, with and without the fetch flag. After every access, a bench model of pending and active bytes is compared with the outputs, so a commit that comes one edge late or is lost shows up as a mismatch.

// File: rtl/cfgw_pkg.sv
// Package: shared constants and reset values for the configuration window.
// Assumes a 16-bit host address and a 64-byte window.
package cfgw_pkg;
    localparam int ADDR_W   = 16;
    localparam int OFF_W    = 6;
    localparam int NBANK    = 4;
    localparam int BANK_B   = 6;
    localparam int NBANKB   = NBANK * BANK_B;
    localparam int NDEF     = NBANKB + 1;
    localparam int DEF_IW   = $clog2(NDEF);

    localparam logic [ADDR_W-1:0] WIN_LOW = 16'h0F80;

    localparam logic [OFF_W-1:0] OF_MODE  = 6'h00;
    localparam logic [OFF_W-1:0] OF_FA0   = 6'h01;
    localparam logic [OFF_W-1:0] OF_FA1   = 6'h02;
    localparam logic [OFF_W-1:0] OF_FA2   = 6'h03;
    localparam logic [OFF_W-1:0] OF_FDAT  = 6'h04;
    localparam logic [OFF_W-1:0] OF_BLK   = 6'h05;
    localparam logic [OFF_W-1:0] OF_DEFLST= 6'h1D;
    localparam logic [OFF_W-1:0] OF_SLOT  = 6'h1E;
    localparam logic [OFF_W-1:0] OF_MCOPY = 6'h1F;
    localparam logic [OFF_W-1:0] OF_FCFG  = 6'h20;
    localparam logic [OFF_W-1:0] OF_VOL   = 6'h22;
    localparam logic [OFF_W-1:0] OF_EE    = 6'h23;
    localparam logic [OFF_W-1:0] OF_VER0  = 6'h2C;
    localparam logic [OFF_W-1:0] OF_VER1  = 6'h2D;
    localparam logic [OFF_W-1:0] OF_VER2  = 6'h2E;

    localparam logic [7:0] MODE_RST = 8'h20;
    localparam logic [7:0] VOL_RST  = 8'h1B;
    localparam logic [7:0] FCFG_RST = 8'h02;
    localparam logic [7:0] SLOT_RST = 8'h00;

    // Reset value of deferrable byte i (0 = block select, 1.. = bank bytes).
    function automatic logic [7:0] def_rst(input int i);
        int fld;
        int bnk;
        if (i == 0) return 8'h00;
        fld = (i - 1) % BANK_B;
        bnk = (i - 1) / BANK_B;
        case (fld)
            0:       return 8'hF8;
            1:       return 8'h50;
            2:       return 8'h00;
            3:       return (bnk == 0) ? 8'h85 : 8'h00;
            4:       return 8'h03;
            default: return 8'h40;
        endcase
    endfunction
endpackage

// File: rtl/cfgw_decode.sv
// Window decoder: claims an access when it falls inside the 64-byte window
// whose base is chosen by the two segment bits; hidden blocks all claims.
// Assumes the window low address keeps bits 15:14 clear.
module cfgw_decode
    import cfgw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              access,
    input  logic [1:0]        seg,
    input  logic              hide,
    output logic              hit,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [ADDR_W-3-OFF_W:0] MID = WIN_LOW[ADDR_W-3:OFF_W];

    // Compare the segment and the fixed middle bits of the address.
    always_comb begin
        hit    = access && !hide
                 && (addr[ADDR_W-1:ADDR_W-2] == seg)
                 && (addr[ADDR_W-3:OFF_W] == MID);
        offset = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/cfgw_trigger.sv
// Commit trigger: decides when the pending copy moves into the active copy.
// Assumes reads and writes never share a cycle.
module cfgw_trigger
    import cfgw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FETCH_ADDR = 16'h0000,
    parameter logic [ADDR_W-1:0] READ_ADDR  = 16'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              fetch,
    input  logic              defer_on,
    input  logic              by_read,
    input  logic              mode_wr,
    input  logic              mode_wr_defer,
    output logic              commit,
    output logic              clear_defer
);
    logic fetch_evt;
    logic read_evt;
    logic trig;

    // Classify the host access as one of the two trigger events.
    always_comb begin
        fetch_evt = rd && fetch && (addr == FETCH_ADDR);
        read_evt  = rd && (addr == READ_ADDR);
        trig      = by_read ? read_evt : fetch_evt;
    end

    // Commit on a trigger, or when a mode write leaves deferred mode.
    always_comb begin
        clear_defer = defer_on && trig;
        commit      = clear_defer || (defer_on && mode_wr && !mode_wr_defer);
    end
endmodule

// File: rtl/cfgw_defer_bank.sv
// Pending/active register pairs for the deferrable bytes.
// Writes always load the pending byte; the active byte follows at once when
// immediate is set, otherwise only when commit copies every pending byte.
module cfgw_defer_bank
    import cfgw_pkg::*;
#(
    parameter int N  = NDEF,
    parameter int IW = DEF_IW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [IW-1:0]  wr_idx,
    input  logic [7:0]     wr_data,
    input  logic           immediate,
    input  logic           commit,
    output logic [N*8-1:0] active
);
    logic [N*8-1:0] pend;

    for (genvar g = 0; g < N; g++) begin : g_byte
        logic sel;
        // Byte select for this slot.
        always_comb sel = wr && (wr_idx == IW'(g));

        // Pending byte: takes every host write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)   pend[g*8 +: 8] <= def_rst(g);
            else if (sel) pend[g*8 +: 8] <= wr_data;
        end

        // Active byte: host write when immediate, else copy on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)                active[g*8 +: 8] <= def_rst(g);
            else if (sel && immediate) active[g*8 +: 8] <= wr_data;
            else if (commit)           active[g*8 +: 8] <= pend[g*8 +: 8];
        end
    end
endmodule

// File: rtl/cfg_window_regs.sv
// Relocatable configuration register window (top).
// Holds the mode, flash access, EEPROM bit port, volume, slot and
// deferrable mapper bytes; returns read data one edge after a read.
// Assumes bus_rd and bus_wr are never high together.
module cfg_window_regs
    import cfgw_pkg::*;
#(
    parameter logic [23:0] FW_VERSION = 24'h323530
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_fetch,
    input  logic [7:0]        bus_wdata,
    output logic              win_sel,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        mode_o,
    output logic [7:0]        slot_cfg_o,
    output logic [7:0]        flash_cfg_o,
    output logic [7:0]        volume_o,
    output logic [7:0]        blk_sel_o,
    output logic [NBANKB*8-1:0] bank_cfg_o,
    output logic [22:0]       flash_addr_o,
    output logic [7:0]        flash_wdata_o,
    output logic              flash_wr_o,
    output logic              flash_rd_o,
    input  logic [7:0]        flash_rdata,
    output logic              ee_cs_o,
    output logic              ee_clk_o,
    output logic              ee_di_o,
    input  logic              ee_do_i
);
    logic [OFF_W-1:0]  off;
    logic              wr_hit;
    logic              rd_hit;
    logic              mode_wr;
    logic              def_wr;
    logic [DEF_IW-1:0] def_idx;
    logic              commit;
    logic              clear_defer;
    logic [NDEF*8-1:0] active;
    logic [2:0]        ee_q;

    cfgw_decode u_dec (
        .addr   (bus_addr),
        .access (bus_rd || bus_wr),
        .seg    (mode_o[6:5]),
        .hide   (mode_o[7]),
        .hit    (win_sel),
        .offset (off)
    );

    // Qualify host accesses by the window claim and decode the targets.
    always_comb begin
        wr_hit  = bus_wr && win_sel;
        rd_hit  = bus_rd && win_sel;
        mode_wr = wr_hit && (off == OF_MODE || off == OF_MCOPY);
        def_wr  = wr_hit && (off >= OF_BLK) && (off <= OF_DEFLST);
        def_idx = DEF_IW'(off - OF_BLK);
        flash_rd_o = rd_hit && (off == OF_FDAT);
    end

    cfgw_trigger u_trig (
        .addr          (bus_addr),
        .rd            (bus_rd),
        .fetch         (bus_fetch),
        .defer_on      (mode_o[3]),
        .by_read       (mode_o[2]),
        .mode_wr       (mode_wr),
        .mode_wr_defer (bus_wdata[3]),
        .commit        (commit),
        .clear_defer   (clear_defer)
    );

    cfgw_defer_bank #(.N(NDEF), .IW(DEF_IW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (def_wr),
        .wr_idx    (def_idx),
        .wr_data   (bus_wdata),
        .immediate (!mode_o[3]),
        .commit    (commit),
        .active    (active)
    );

    // Split the active vector into block select and bank bytes.
    always_comb begin
        blk_sel_o  = active[7:0];
        bank_cfg_o = active[NDEF*8-1:8];
    end

    // Mode byte: host write wins, else a trigger clears the defer flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_o <= MODE_RST;
        else if (mode_wr)     mode_o <= bus_wdata;
        else if (clear_defer) mode_o <= mode_o & 8'hF7;
    end

    // Plain write-only bytes: slot, flash configuration, volume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cfg_o  <= SLOT_RST;
            flash_cfg_o <= FCFG_RST;
            volume_o    <= VOL_RST;
        end else if (wr_hit) begin
            if (off == OF_SLOT) slot_cfg_o  <= bus_wdata;
            if (off == OF_FCFG) flash_cfg_o <= bus_wdata;
            if (off == OF_VOL)  volume_o    <= bus_wdata;
        end
    end

    // Flash address bytes, low to high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_addr_o <= '0;
        end else if (wr_hit) begin
            if (off == OF_FA0) flash_addr_o[7:0]   <= bus_wdata;
            if (off == OF_FA1) flash_addr_o[15:8]  <= bus_wdata;
            if (off == OF_FA2) flash_addr_o[22:16] <= bus_wdata[6:0];
        end
    end

    // Flash data port write: one-cycle pulse with captured data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_wr_o    <= 1'b0;
            flash_wdata_o <= '0;
        end else begin
            flash_wr_o <= wr_hit && (off == OF_FDAT);
            if (wr_hit && off == OF_FDAT) flash_wdata_o <= bus_wdata;
        end
    end

    // EEPROM bit port: chip select, clock, data out.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ee_q <= '0;
        else if (wr_hit && off == OF_EE) ee_q <= bus_wdata[3:1];
    end

    always_comb begin
        ee_cs_o  = ee_q[2];
        ee_clk_o = ee_q[1];
        ee_di_o  = ee_q[0];
    end

    // Registered read mux for the readable offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'hFF;
        end else if (rd_hit) begin
            case (off)
                OF_FDAT: bus_rdata <= flash_rdata;
                OF_EE:   bus_rdata <= {4'b0000, ee_q, ee_do_i};
                OF_VER0: bus_rdata <= FW_VERSION[23:16];
                OF_VER1: bus_rdata <= FW_VERSION[15:8];
                OF_VER2: bus_rdata <= FW_VERSION[7:0];
                default: bus_rdata <= 8'hFF;
            endcase
        end
    end
endmodule

// File: rtl/cfgw_checker.sv
// Property checker for the configuration window, bound to the top module.
module cfgw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        bus_fetch,
    input logic [7:0]  bus_wdata,
    input logic        win_sel,
    input logic [7:0]  mode_o,
    input logic [7:0]  volume_o,
    input logic [7:0]  blk_sel_o,
    input logic        flash_wr_o,
    input logic        flash_rd_o
);
    // R1
    reset_val_chk: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (mode_o == 8'h20 && volume_o == 8'h1B && blk_sel_o == 8'h00));

    // R3
    hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[7] |-> !win_sel);

    // R5
    immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o[3] && bus_wr && win_sel && bus_addr[5:0] == 6'h05) |=> (blk_sel_o == $past(bus_wdata)));

    // R6
    deferred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[3] && bus_wr && win_sel && bus_addr[5:0] == 6'h05) |=> $stable(blk_sel_o));

    // R7
    fetch_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[3] && !mode_o[2] && bus_rd && bus_fetch && bus_addr == 16'h0000) |=> !mode_o[3]);

    // R7
    data_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[3] && !mode_o[2] && bus_rd && !bus_fetch && bus_addr == 16'h0000)
        |=> (mode_o[3] && $stable(blk_sel_o)));

    // R8
    read_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[3] && mode_o[2] && bus_rd && bus_addr == 16'h4000) |=> !mode_o[3]);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_wr_o, flash_rd_o}));
endmodule

bind cfg_window_regs cfgw_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_fetch  (bus_fetch),
    .bus_wdata  (bus_wdata),
    .win_sel    (win_sel),
    .mode_o     (mode_o),
    .volume_o   (volume_o),
    .blk_sel_o  (blk_sel_o),
    .flash_wr_o (flash_wr_o),
    .flash_rd_o (flash_rd_o)
);

// File: tb/cfg_window_regs_tb_top.sv
// Bench for the configuration window: directed corners plus a seeded random
// mix of deferred writes, mode changes and trigger reads, against a model.
module cfg_window_regs_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic         bus_rd = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_fetch = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   flash_rdata = '0;
    logic         ee_do_i = 1'b0;
    logic         win_sel;
    logic [7:0]   bus_rdata, mode_o, slot_cfg_o, flash_cfg_o, volume_o, blk_sel_o;
    logic [191:0] bank_cfg_o;
    logic [22:0]  flash_addr_o;
    logic [7:0]   flash_wdata_o;
    logic         flash_wr_o, flash_rd_o, ee_cs_o, ee_clk_o, ee_di_o;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_mode;
    logic [7:0] m_pend [25];
    logic [7:0] m_act  [25];

    always #5 clk = ~clk;

    cfg_window_regs dut_i (.*);

    function automatic logic [7:0] rst_byte(input int i);
        logic [7:0] row [6];
        row = '{8'hF8, 8'h50, 8'h00, 8'h00, 8'h03, 8'h40};
        if (i == 0) return 8'h00;
        if (i == 4) return 8'h85;
        return row[(i - 1) % 6];
    endfunction

    function automatic logic [191:0] pack_act();
        logic [191:0] v;
        for (int i = 0; i < 24; i++) v[i*8 +: 8] = m_act[i+1];
        return v;
    endfunction

    function automatic logic [15:0] base_of(input logic [1:0] s);
        return {s, 14'h0F80};
    endfunction

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_commit();
        for (int i = 0; i < 25; i++) m_act[i] = m_pend[i];
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic f);
        bus_addr = a; bus_fetch = f; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_fetch = 1'b0;
    endtask

    // Model-tracked write to offset 00h/1Fh or a deferrable offset.
    task automatic mwr(input logic [5:0] off, input logic [7:0] d);
        wr(base_of(m_mode[6:5]) + 16'(off), d);
        if (off == 6'h00 || off == 6'h1F) begin
            if (m_mode[3] && !d[3]) m_commit();
            m_mode = d;
        end else if (off >= 6'h05 && off <= 6'h1D) begin
            m_pend[off - 6'h05] = d;
            if (!m_mode[3]) m_act[off - 6'h05] = d;
        end
    endtask

    task automatic mrd(input logic [15:0] a, input logic f);
        logic trig;
        rd(a, f);
        trig = m_mode[2] ? (a == 16'h4000) : (f && a == 16'h0000);
        if (m_mode[3] && trig) begin
            m_commit();
            m_mode[3] = 1'b0;
        end
    endtask

    task automatic cmp_all(input string req);
        check(req, {184'd0, blk_sel_o}, {184'd0, m_act[0]});
        check(req, bank_cfg_o, pack_act());
        check(req, {184'd0, mode_o}, {184'd0, m_mode});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_1234));
        m_mode = 8'h20;
        for (int i = 0; i < 25; i++) begin
            m_pend[i] = rst_byte(i);
            m_act[i]  = rst_byte(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", {184'd0, volume_o}, {184'd0, 8'h1B});
        check("R1", {184'd0, flash_cfg_o}, {184'd0, 8'h02});
        check("R1", {184'd0, slot_cfg_o}, {184'd0, 8'h00});
        cmp_all("R1");

        // R2 window edges at the reset base
        bus_addr = 16'h4FBF; bus_rd = 1'b1; #1;
        check("R2", {191'd0, win_sel}, 192'd1);
        bus_addr = 16'h4FC0; #1;
        check("R2", {191'd0, win_sel}, 192'd0);
        bus_addr = 16'h0F80; #1;
        check("R2", {191'd0, win_sel}, 192'd0);
        bus_rd = 1'b0;

        // R12 version, write-only read-back and plain bytes
        rd(16'h4FAC, 1'b0); check("R12", {184'd0, bus_rdata}, {184'd0, 8'h32});
        rd(16'h4FAE, 1'b0); check("R12", {184'd0, bus_rdata}, {184'd0, 8'h30});
        rd(16'h4F85, 1'b0); check("R12", {184'd0, bus_rdata}, {184'd0, 8'hFF});
        wr(16'h4FA2, 8'h80); check("R12", {184'd0, volume_o}, {184'd0, 8'h80});
        wr(16'h4FA0, 8'h05); check("R12", {184'd0, flash_cfg_o}, {184'd0, 8'h05});
        wr(16'h4F9E, 8'hA7); check("R12", {184'd0, slot_cfg_o}, {184'd0, 8'hA7});

        // R10 flash address, write pulse and read strobe
        wr(16'h4F81, 8'h34); wr(16'h4F82, 8'h12); wr(16'h4F83, 8'hFF);
        check("R10", {169'd0, flash_addr_o}, {169'd0, 23'h7F1234});
        wr(16'h4F84, 8'h9C);
        check("R10", {183'd0, flash_wr_o, flash_wdata_o}, {183'd0, 1'b1, 8'h9C});
        @(negedge clk);
        check("R10", {191'd0, flash_wr_o}, 192'd0);
        flash_rdata = 8'h6E; bus_addr = 16'h4F84; bus_rd = 1'b1; #1;
        check("R10", {191'd0, flash_rd_o}, 192'd1);
        @(negedge clk); bus_rd = 1'b0;
        check("R10", {184'd0, bus_rdata}, {184'd0, 8'h6E});

        // R11 EEPROM bit port
        wr(16'h4FA3, 8'hFA); ee_do_i = 1'b1;
        check("R11", {189'd0, ee_cs_o, ee_clk_o, ee_di_o}, {189'd0, 3'b101});
        rd(16'h4FA3, 1'b0); check("R11", {184'd0, bus_rdata}, {184'd0, 8'h0B});

        // R4 copy offset relocates the window to 8F80h
        mwr(6'h1F, 8'h40); cmp_all("R4");
        mwr(6'h05, 8'h11); cmp_all("R5");
        wr(16'h4F85, 8'h77); cmp_all("R2");

        // R9 directed: pending change then mode write leaving deferral
        mwr(6'h00, 8'h48); mwr(6'h05, 8'h22); mwr(6'h06, 8'h99); cmp_all("R6");
        mwr(6'h00, 8'h40); cmp_all("R9");

        // R7 / R8 directed non-triggers and triggers
        mwr(6'h00, 8'h48); mwr(6'h05, 8'h33);
        mrd(16'h0000, 1'b0); cmp_all("R7");
        mrd(16'h4000, 1'b0); cmp_all("R7");
        mrd(16'h0000, 1'b1); cmp_all("R7");
        mwr(6'h00, 8'h4C); mwr(6'h07, 8'h5A);
        mrd(16'h0000, 1'b1); cmp_all("R8");
        mrd(16'h4000, 1'b1); cmp_all("R8");

        // Random mix for R4-R9
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 8);
            d  = 8'($urandom);
            case (op)
                0, 1, 2: begin
                    mwr(6'(5 + $urandom % 25), d);
                    cmp_all(m_mode[3] ? "R6" : "R5");
                end
                3: begin
                    mwr(($urandom % 2) ? 6'h00 : 6'h1F, {1'b0, d[6:0]});
                    cmp_all("R9");
                end
                4: begin mrd(16'h0000, 1'b1); cmp_all("R7"); end
                5: begin mrd(16'h4000, d[0]); cmp_all("R8"); end
                6: begin mrd(16'h0000, 1'b0); cmp_all("R7"); end
                default: begin mrd(16'h4000, 1'b1); cmp_all("R8"); end
            endcase
        end

        // R3 hide the window; writes and reads in range are ignored
        mwr(6'h00, 8'hA0);
        bus_addr = 16'h4F85; bus_wr = 1'b1; bus_wdata = 8'hEE; #1;
        check("R3", {191'd0, win_sel}, 192'd0);
        @(negedge clk); bus_wr = 1'b0;
        cmp_all("R3");
        rd(16'h4FAC, 1'b0);
        check("R3", {184'd0, bus_rdata}, {184'd0, 8'h0B});

        finish_run();
    end
endmodule